// File: doc/BRIEF.md
# PWM generator with coded prescaler

This block produces one pulse-width-modulated output from a 24 MHz reference clock. A 4-bit divider code picks the tick rate. The legal codes choose one of ten fixed divide ratios between 120 and 72000, or they pass the clock through undivided. Five codes are reserved and are refused. One PWM period lasts span+1 ticks. The output sits at its active level for the first mark ticks of each period. A polarity bit decides whether the active level is high or low.

Software sets the block up through a small write port with four addresses and reads the values back combinationally. New divider, span and mark values are held in shadow registers. They move into the live copies only at a period boundary or when the block starts, so a period is never cut short. While the block is stopped, the output rests at the inactive level and the counters are held cleared. Writes to the divider, span and mark addresses are dropped while the block is stopped. A refused divider code leaves the previous code in place and sets a sticky error flag.

Top module: `pwm_coded`

## Requirements
- R1: After reset the output is 0, the error flag is 0 and all four read addresses return 0.
- R2: The divider code (address 1, bits 3:0) selects a tick period in clock cycles: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1 (bypass). A legal code reads back unchanged.
- R3: Codes 5, 6, 7, 13 and 14 are refused. The stored code keeps its previous value, and the error flag (address 1 read bit 4, and port `code_err`) goes to 1. The flag stays at 1 through later writes until a control write with bit 2 set clears it.
- R4: While running, each period lasts (span+1)×ratio clock cycles. Span is at address 2 and mark at address 3. With 0 < mark ≤ span, the output is active for mark×ratio cycles and then inactive for (span+1−mark)×ratio cycles.
- R5: Control bit 1 (polarity) set to 0 makes the active level 1 and the inactive level 0. Set to 1, the active level is 0 and the inactive level is 1.
- R6: While control bit 0 (run) is 0, writes to addresses 1, 2 and 3 are ignored, and their read-back is unchanged.
- R7: Divider, span and mark writes made while running take effect only at the next period boundary, so the current period completes with the old values. A 0→1 change of run loads the written values at once.
- R8: From the second clock edge after run is written to 0, the output holds the inactive level of the current polarity.
- R9: While running, a mark of 0 keeps the output at the inactive level, and a mark greater than span keeps it at the active level.
- R10: With bypass (code 15), span 1 and mark 1, the output alternates level on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 divider code, 2 span, 3 mark |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | DATA_W | Combinational read-back of the selected register |
| pwm_out | output | 1 | PWM waveform |
| code_err | output | 1 | Sticky refused-code flag |

## Verification
The bound checker watches, on every cycle, the properties that hold from cycle to cycle. These are the resting level while stopped, that live settings change only at a boundary or a start, that the tick counter stays within the span, and that the error flag stays set. It also checks that refused codes never reach the divider, that writes while stopped leave the shadows alone, and that bypass ticks on every cycle. The exact divide ratios, the active and inactive phase lengths, and the order in which buffered settings appear across a period boundary can only be shown by the bench. It measures the waveform at the pin for each of its directed scenarios.

// File: rtl/pwm_coded_pkg.sv
package pwm_coded_pkg;

  localparam int CODE_W  = 4;
  localparam int RATIO_W = 17;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_DIVSEL = 2'd1,
    A_SPAN   = 2'd2,
    A_MARK   = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_POL = 1;
  localparam int CTRL_CLR = 2;

  // Legal divider codes: a dense low group, a dense high group, bypass.
  function automatic logic code_is_valid(code_t c);
    return (c <= code_t'(4)) || ((c >= code_t'(8)) && (c <= code_t'(12))) || (c == '1);
  endfunction

  // Clock cycles per tick; 0 marks a refused code.
  function automatic ratio_t code_ratio(code_t c);
    ratio_t r;
    unique case (c)
      4'h0:    r = ratio_t'(120);
      4'h1:    r = ratio_t'(180);
      4'h2:    r = ratio_t'(240);
      4'h3:    r = ratio_t'(360);
      4'h4:    r = ratio_t'(480);
      4'h8:    r = ratio_t'(12000);
      4'h9:    r = ratio_t'(24000);
      4'hA:    r = ratio_t'(36000);
      4'hB:    r = ratio_t'(48000);
      4'hC:    r = ratio_t'(72000);
      4'hF:    r = ratio_t'(1);
      default: r = '0;
    endcase
    return r;
  endfunction

  // Active phase: the first 'mark' ticks of the period.
  function automatic logic in_mark(logic [15:0] cnt, logic [15:0] mark);
    return cnt < mark;
  endfunction

endpackage

// File: rtl/pwm_coded_regs.sv
module pwm_coded_regs
  import pwm_coded_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              run_q,
  output logic              pol_q,
  output code_t             code_sh,
  output logic [DATA_W-1:0] span_sh,
  output logic [DATA_W-1:0] mark_sh,
  output logic              err_q,
  output logic              clr_evt
);

  localparam int ERR_BIT = CODE_W;

  logic   code_wr;
  logic   bad_evt;
  code_t  code_in;

  assign code_in = wr_data[CODE_W-1:0];
  assign clr_evt = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_CLR];
  assign code_wr = wr_en && run_q && (wr_addr == A_DIVSEL);
  assign bad_evt = code_wr && !code_is_valid(code_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pol_q   <= 1'b0;
      code_sh <= '0;
      span_sh <= '0;
      mark_sh <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == A_CTRL)) begin
        run_q <= wr_data[CTRL_RUN];
        pol_q <= wr_data[CTRL_POL];
      end
      if (clr_evt)
        err_q <= 1'b0;
      else if (bad_evt)
        err_q <= 1'b1;
      if (code_wr && !bad_evt)
        code_sh <= code_in;
      if (wr_en && run_q && (wr_addr == A_SPAN))
        span_sh <= wr_data;
      if (wr_en && run_q && (wr_addr == A_MARK))
        mark_sh <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL: begin
        rd_data[CTRL_RUN] = run_q;
        rd_data[CTRL_POL] = pol_q;
      end
      A_DIVSEL: begin
        rd_data[CODE_W-1:0] = code_sh;
        rd_data[ERR_BIT]    = err_q;
      end
      A_SPAN:  rd_data = span_sh;
      default: rd_data = mark_sh;
    endcase
  end

endmodule

// File: rtl/pwm_coded_prescaler.sv
module pwm_coded_prescaler
  import pwm_coded_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  ratio_t ratio,
  output logic   tick
);

  ratio_t pcnt_q;
  ratio_t last;

  assign last = ratio - ratio_t'(1);
  assign tick = !clr && (pcnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (clr || tick)
      pcnt_q <= '0;
    else
      pcnt_q <= pcnt_q + ratio_t'(1);
  end

endmodule

// File: rtl/pwm_coded_wave.sv
module pwm_coded_wave
  import pwm_coded_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pol,
  input  logic              tick,
  input  code_t             code_sh,
  input  logic [DATA_W-1:0] span_sh,
  input  logic [DATA_W-1:0] mark_sh,
  output logic              live_q,
  output logic              start_evt,
  output logic              wrap_evt,
  output logic [DATA_W-1:0] cnt_q,
  output code_t             code_cur,
  output logic [DATA_W-1:0] span_cur,
  output logic [DATA_W-1:0] mark_cur,
  output logic              pwm_out
);

  logic load;

  assign start_evt = run && !live_q;
  assign wrap_evt  = live_q && tick && (cnt_q == span_cur);
  assign load      = start_evt || wrap_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      cnt_q    <= '0;
      code_cur <= '0;
      span_cur <= '0;
      mark_cur <= '0;
      pwm_out  <= 1'b0;
    end else if (!run) begin
      live_q  <= 1'b0;
      cnt_q   <= '0;
      pwm_out <= pol;
    end else begin
      live_q <= 1'b1;
      if (load) begin
        code_cur <= code_sh;
        span_cur <= span_sh;
        mark_cur <= mark_sh;
        cnt_q    <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + DATA_W'(1);
      end
      pwm_out <= live_q ? (in_mark(16'(cnt_q), 16'(mark_cur)) ^ pol) : pol;
    end
  end

endmodule

// File: rtl/pwm_coded.sv
module pwm_coded
  import pwm_coded_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out,
  output logic              code_err
);

  logic              run_q;
  logic              pol_q;
  code_t             code_sh;
  logic [DATA_W-1:0] span_sh;
  logic [DATA_W-1:0] mark_sh;
  logic              err_q;
  logic              clr_evt;

  logic              tick;
  logic              live_q;
  logic              start_evt;
  logic              wrap_evt;
  logic [DATA_W-1:0] cnt_q;
  code_t             code_cur;
  logic [DATA_W-1:0] span_cur;
  logic [DATA_W-1:0] mark_cur;
  ratio_t            ratio_cur;

  assign ratio_cur = code_ratio(code_cur);
  assign code_err  = err_q;

  pwm_coded_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .run_q   (run_q),
    .pol_q   (pol_q),
    .code_sh (code_sh),
    .span_sh (span_sh),
    .mark_sh (mark_sh),
    .err_q   (err_q),
    .clr_evt (clr_evt)
  );

  pwm_coded_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!live_q),
    .ratio (ratio_cur),
    .tick  (tick)
  );

  pwm_coded_wave #(.DATA_W(DATA_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .pol       (pol_q),
    .tick      (tick),
    .code_sh   (code_sh),
    .span_sh   (span_sh),
    .mark_sh   (mark_sh),
    .live_q    (live_q),
    .start_evt (start_evt),
    .wrap_evt  (wrap_evt),
    .cnt_q     (cnt_q),
    .code_cur  (code_cur),
    .span_cur  (span_cur),
    .mark_cur  (mark_cur),
    .pwm_out   (pwm_out)
  );

endmodule

// File: rtl/pwm_coded_chk.sv
module pwm_coded_chk
  import pwm_coded_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic              run_q,
  input logic              pol_q,
  input code_t             code_sh,
  input logic [DATA_W-1:0] span_sh,
  input logic [DATA_W-1:0] mark_sh,
  input logic              err_q,
  input logic              clr_evt,
  input logic              tick,
  input logic              live_q,
  input logic              start_evt,
  input logic              wrap_evt,
  input logic [DATA_W-1:0] cnt_q,
  input code_t             code_cur,
  input logic [DATA_W-1:0] span_cur,
  input logic              pwm_out
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (pwm_out == $past(pol_q))); // R8

  AST_LIVE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_is_valid(code_cur)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_evt) |=> err_q); // R3

  AST_CNT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cnt_q <= span_cur)); // R4

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(span_cur) |-> $past(wrap_evt || start_evt)); // R7

  AST_STOPPED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && wr_en && (wr_addr != A_CTRL)) |=>
      ($stable(span_sh) && $stable(mark_sh) && $stable(code_sh))); // R6

  AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && (code_cur == '1)) |-> tick); // R2

endmodule

bind pwm_coded pwm_coded_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .run_q     (run_q),
  .pol_q     (pol_q),
  .code_sh   (code_sh),
  .span_sh   (span_sh),
  .mark_sh   (mark_sh),
  .err_q     (err_q),
  .clr_evt   (clr_evt),
  .tick      (tick),
  .live_q    (live_q),
  .start_evt (start_evt),
  .wrap_evt  (wrap_evt),
  .cnt_q     (cnt_q),
  .code_cur  (code_cur),
  .span_cur  (span_cur),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_coded_tb.sv
module pwm_coded_tb;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              pwm_out;
  logic              code_err;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic pol_tb = 1'b0;

  always #2 clk = ~clk;

  pwm_coded #(.DATA_W(DATA_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .code_err (code_err)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [DATA_W-1:0] ctrl_word(input logic run, input logic clr);
    return {13'd0, clr, pol_tb, run};
  endfunction

  // Write shadows while running, then stop and start again to load them.
  task automatic apply(input int code, input int span, input int mark);
    wr(2'd1, DATA_W'(code));
    wr(2'd2, DATA_W'(span));
    wr(2'd3, DATA_W'(mark));
    wr(2'd0, ctrl_word(1'b0, 1'b0));
    wr(2'd0, ctrl_word(1'b1, 1'b0));
  endtask

  // Length of one active phase and the following inactive phase, in cycles.
  task automatic meas(output int a, output int i);
    a = 0; i = 0;
    while ((pwm_out ^ pol_tb) !== 1'b0) @(negedge clk);
    while ((pwm_out ^ pol_tb) !== 1'b1) @(negedge clk);
    while ((pwm_out ^ pol_tb) === 1'b1) begin a++; @(negedge clk); end
    while ((pwm_out ^ pol_tb) === 1'b0) begin i++; @(negedge clk); end
  endtask

  task automatic hold_level(input string req, input logic lvl, input int n);
    int mism = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out !== lvl) mism++;
    end
    check(req, "cycles off the expected level", mism, 0);
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), d);
      check("R1", $sformatf("read addr %0d after reset", k), d, 0);
    end
    check("R1", "pwm_out after reset", pwm_out, 0);
    check("R1", "code_err after reset", code_err, 0);
  endtask

  task automatic t_stopped_writes;
    logic [DATA_W-1:0] d;
    wr(2'd2, 16'd7);
    wr(2'd3, 16'd3);
    wr(2'd1, 16'd9);
    rd(2'd2, d); check("R6", "span after stopped write", d, 0);
    rd(2'd3, d); check("R6", "mark after stopped write", d, 0);
    rd(2'd1, d); check("R6", "code after stopped write", d, 0);
    hold_level("R6", 1'b0, 10);
    wr(2'd0, ctrl_word(1'b1, 1'b0));
  endtask

  task automatic t_bypass;
    int a, i;
    apply(15, 1, 1);
    meas(a, i);
    check("R10", "bypass active cycles", a, 1);
    check("R10", "bypass inactive cycles", i, 1);
  endtask

  task automatic t_ratios;
    int codes [6] = '{0, 1, 2, 3, 4, 8};
    int ratio [6] = '{120, 180, 240, 360, 480, 12000};
    int a, i;
    logic [DATA_W-1:0] d;
    foreach (codes[k]) begin
      apply(codes[k], 1, 1);
      rd(2'd1, d);
      check("R2", $sformatf("code %0d read-back", codes[k]), d, codes[k]);
      meas(a, i);
      check("R2", $sformatf("code %0d active cycles", codes[k]), a, ratio[k]);
      check("R2", $sformatf("code %0d inactive cycles", codes[k]), i, ratio[k]);
    end
    apply(15, 1, 1);
  endtask

  task automatic t_invalid;
    logic [DATA_W-1:0] d;
    apply(3, 1, 1);
    wr(2'd1, 16'd5);
    rd(2'd1, d); check("R3", "code 5 refused, flag set", d, 16'h13);
    check("R3", "code_err after code 5", code_err, 1);
    wr(2'd1, 16'd2);
    rd(2'd1, d); check("R3", "flag sticky across legal write", d, 16'h12);
    wr(2'd1, 16'd14);
    rd(2'd1, d); check("R3", "code 14 refused", d, 16'h12);
    wr(2'd1, 16'd7);
    rd(2'd1, d); check("R3", "code 7 refused", d, 16'h12);
    wr(2'd0, ctrl_word(1'b1, 1'b1));
    rd(2'd1, d); check("R3", "flag cleared by control bit 2", d, 16'h02);
    check("R3", "code_err after clear", code_err, 0);
  endtask

  task automatic t_shape;
    int a, i;
    apply(15, 9, 3);
    meas(a, i);
    check("R4", "span 9 mark 3 active", a, 3);
    check("R4", "span 9 mark 3 inactive", i, 7);
    apply(1, 4, 4);
    meas(a, i);
    check("R4", "span 4 mark 4 active at ratio 180", a, 720);
    check("R4", "span 4 mark 4 inactive at ratio 180", i, 180);
  endtask

  task automatic t_polarity;
    int a, i;
    pol_tb = 1'b1;
    apply(15, 3, 1);
    meas(a, i);
    check("R5", "inverted active cycles", a, 1);
    check("R5", "inverted inactive cycles", i, 3);
    wr(2'd0, ctrl_word(1'b0, 1'b0));
    hold_level("R5", 1'b1, 8);
    wr(2'd0, ctrl_word(1'b1, 1'b0));
    pol_tb = 1'b0;
    wr(2'd0, ctrl_word(1'b1, 1'b0));
  endtask

  task automatic t_extremes;
    apply(15, 3, 0);
    repeat (3) @(negedge clk);
    hold_level("R9", 1'b0, 40);
    apply(15, 3, 5);
    repeat (3) @(negedge clk);
    hold_level("R9", 1'b1, 40);
  endtask

  task automatic t_buffer;
    int n;
    apply(0, 9, 5);
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd3);
    wr(2'd3, 16'd1);
    while (pwm_out !== 1'b0) @(negedge clk);
    n = 0; while (pwm_out === 1'b0) begin n++; @(negedge clk); end
    check("R7", "old period inactive phase", n, 600);
    n = 0; while (pwm_out === 1'b1) begin n++; @(negedge clk); end
    check("R7", "new period active phase", n, 180);
    n = 0; while (pwm_out === 1'b0) begin n++; @(negedge clk); end
    check("R7", "new period inactive phase", n, 540);
  endtask

  task automatic t_disable;
    apply(15, 1, 1);
    repeat (4) @(negedge clk);
    pol_tb = 1'b1;
    wr(2'd0, ctrl_word(1'b0, 1'b0));
    @(negedge clk);
    hold_level("R8", 1'b1, 20);
    pol_tb = 1'b0;
    wr(2'd0, ctrl_word(1'b0, 1'b0));
    @(negedge clk);
    hold_level("R8", 1'b0, 20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped_writes();
    t_bypass();
    t_ratios();
    t_invalid();
    t_shape();
    t_polarity();
    t_extremes();
    t_buffer();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule